// File: doc/BRIEF.md
# UART transmit frame formatter

This block turns one character into an asynchronous serial frame on a single output line. A character is written into a one-entry holding register. At the next bit-rate tick after the shifter goes free, the character moves into the shifter and goes out as a frame: a low start slot, then the character slots, then one high stop slot. Every slot lasts exactly one tick period. The tick comes from an external baud generator.

The character is either 8 or 9 slots long. With parity on, the generated parity bit replaces the final character slot. This gives 7 data bits plus parity in 8-slot mode, or 8 data bits plus parity in 9-slot mode. With parity off in 9-slot mode, the ninth slot carries a bit supplied by software, which is how mark or space parity is produced. Two further controls reverse the slot order and invert the line. A break control sends all-zero frames for as long as it is held. Two flags report the state of the transmitter: the holding register is empty, and the transmitter is completely idle.

Top module: `uart_tx_framer`

## Requirements
- R1: Out of reset `txd` is 1 (idle), `dre` is 1 and `tcf` is 1.
- R2: With `cfg_nine`=1 and `cfg_par_en`=0, a frame is a start 0, `wr_data[0]`..`wr_data[7]`, then `wr_bit9`, then a stop 1 (11 slots).
- R3: With `cfg_nine`=0 and `cfg_par_en`=0, a frame is a start 0, `wr_data[0]`..`wr_data[7]`, then a stop 1 (10 slots).
- R4: With `cfg_nine`=1 and `cfg_par_en`=1, the ninth character slot is the parity of `wr_data[7:0]`, and `wr_bit9` is not sent. When `cfg_par_odd`=0 the parity makes the count of ones even; when `cfg_par_odd`=1 it makes the count odd.
- R5: With `cfg_nine`=0 and `cfg_par_en`=1, the slots are `wr_data[0]`..`wr_data[6]` followed by the parity of those 7 bits (same polarity rule as R4). `wr_data[7]` is not sent.
- R6: With `cfg_msb_first`=1, the N character slots of R2..R5 are sent in reverse order. Bit N-1 of the character (parity or ninth bit) goes first. Start and stop slots do not move.
- R7: With `cfg_tx_inv`=1, every level on `txd` is inverted, including idle, start, stop and break.
- R8: While `cfg_brk`=1, the block sends back-to-back all-zero frames of N+2 slots, and each one starts at a tick when the shifter is free. When `cfg_brk` is released, the break frame in progress finishes and the line returns to idle 1.
- R9: A write (`wr_valid`) is accepted only while `dre`=1, and it drops `dre` after that edge. A write while `dre`=0 is ignored and is never sent. `dre` rises again at the tick where the shifter takes the character.
- R10: `tcf` is 1 only when the shifter is idle and the holding register is empty. It is 0 from a write, and during break frames, until the stop slot of the final frame ends.
- R11: A character that is waiting when a stop slot ends starts its start slot at that same tick, with no idle slot in between.
- R12: A character written into an idle block starts its start slot at the first tick after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle bit-rate strobe |
| wr_valid | input | 1 | Write a character into the holding register |
| wr_data | input | 8 | Character data |
| wr_bit9 | input | 1 | Software ninth bit for 9-slot frames without parity |
| cfg_nine | input | 1 | 1 = 9 character slots, 0 = 8 |
| cfg_par_en | input | 1 | Generate parity in the last character slot |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_msb_first | input | 1 | Reverse character slot order |
| cfg_tx_inv | input | 1 | Invert the line |
| cfg_brk | input | 1 | Send break frames while set |
| txd | output | 1 | Serial line |
| dre | output | 1 | Holding register empty |
| tcf | output | 1 | Transmitter idle and nothing pending |

## Verification
Frames are checked slot by slot against a character built arithmetically in the bench. The checks run over all sixteen combinations of slot count, parity enable, parity type and bit order, with 128 data values for each combination and an alternating ninth bit. Together these separate a parity bit from a passed-through data bit or ninth bit, and odd parity from even. They also tell a reversed order from a shifted one. Single-character traffic checks that the start lands on the first tick. A write followed by a second and a third write checks gap-free chaining and that a write to a full holding register is dropped. The break sequence is released part-way through a frame to confirm the frame completes. Inverted frames confirm that the idle level also flips.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int CHAR_MAX  = 9;
  localparam int FRAME_MAX = CHAR_MAX + 2;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  typedef struct packed {
    logic nine;
    logic par_en;
    logic par_odd;
    logic msb_first;
  } fmt_t;
endpackage

// File: rtl/uart_tx_charbuild.sv
module uart_tx_charbuild
  import uart_tx_pkg::*;
(
  input  logic [7:0]          data,
  input  logic                bit9,
  input  fmt_t                fmt,
  output logic [CHAR_MAX-1:0] slots
);
  logic                par9, par8;
  logic [CHAR_MAX-1:0] lsb;

  always_comb begin
    par9 = (^data) ^ fmt.par_odd;
    par8 = (^data[6:0]) ^ fmt.par_odd;
    if (fmt.nine) lsb = {(fmt.par_en ? par9 : bit9), data};
    else          lsb = {1'b0, (fmt.par_en ? par8 : data[7]), data[6:0]};
  end

  // slot i is sent i-th after the start slot
  for (genvar i = 0; i < CHAR_MAX; i++) begin : g_ord
    if (i < CHAR_MAX - 1) begin : g_mid
      assign slots[i] = !fmt.msb_first ? lsb[i]
                      : (fmt.nine ? lsb[CHAR_MAX-1-i] : lsb[CHAR_MAX-2-i]);
    end else begin : g_top
      assign slots[i] = (!fmt.msb_first || fmt.nine) ? lsb[i - (fmt.msb_first ? i : 0)] : 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                pend,
  input  logic                brk,
  input  logic                nine,
  input  logic                inv,
  input  logic [CHAR_MAX-1:0] slots,
  output logic                load,
  output logic                idle_nxt,
  output logic                txd
);
  logic                 busy_q, busy_d, brk_q, brk_d, at_end, line_d;
  logic [FRAME_MAX-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    brk_d  = brk_q;
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    load   = 1'b0;
    at_end = !busy_q || (cnt_q == CNT_W'(1));
    if (tick) begin
      if (at_end) begin
        if (brk || pend) begin
          load   = !brk;
          busy_d = 1'b1;
          brk_d  = brk;
          cnt_d  = nine ? CNT_W'(FRAME_MAX) : CNT_W'(FRAME_MAX - 1);
          if (brk)       sr_d = '0;
          else if (nine) sr_d = {1'b1, slots, 1'b0};
          else           sr_d = {2'b11, slots[CHAR_MAX-2:0], 1'b0};
        end else begin
          busy_d = 1'b0;
          brk_d  = 1'b0;
        end
      end else begin
        sr_d  = sr_q >> 1;
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
    line_d   = busy_d ? sr_d[0] : 1'b1;
    idle_nxt = !busy_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      brk_q  <= 1'b0;
      sr_q   <= '0;
      cnt_q  <= '0;
      txd    <= 1'b1;
    end else begin
      busy_q <= busy_d;
      brk_q  <= brk_d;
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      txd    <= line_d ^ inv;
    end
  end

  assert_slot_held_R12: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !tick) |=> ($stable(sr_q) && $stable(cnt_q)));
  assert_frame_len_R2: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q >= CNT_W'(1) && cnt_q <= CNT_W'(FRAME_MAX)));
  assert_break_low_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && brk_q && !$past(rst)) |-> (txd == $past(inv)));
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !$past(rst)) |-> (txd == !$past(inv)));
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  input  logic       wr_bit9,
  input  logic       cfg_nine,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_msb_first,
  input  logic       cfg_tx_inv,
  input  logic       cfg_brk,
  output logic       txd,
  output logic       dre,
  output logic       tcf
);
  logic                hold_full_q, hold_full_d, hold_b9_q, accept, load, idle_nxt;
  logic [7:0]          hold_data_q;
  logic [CHAR_MAX-1:0] slots;
  fmt_t                fmt;

  assign fmt    = '{nine: cfg_nine, par_en: cfg_par_en, par_odd: cfg_par_odd,
                    msb_first: cfg_msb_first};
  assign accept = wr_valid && !hold_full_q;

  always_comb begin
    hold_full_d = hold_full_q;
    if (accept)    hold_full_d = 1'b1;
    else if (load) hold_full_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full_q <= 1'b0;
      hold_data_q <= '0;
      hold_b9_q   <= 1'b0;
      tcf         <= 1'b1;
    end else begin
      hold_full_q <= hold_full_d;
      tcf         <= idle_nxt && !hold_full_d;
      if (accept) begin
        hold_data_q <= wr_data;
        hold_b9_q   <= wr_bit9;
      end
    end
  end

  assign dre = !hold_full_q;

  uart_tx_charbuild u_char (
    .data  (hold_data_q),
    .bit9  (hold_b9_q),
    .fmt   (fmt),
    .slots (slots)
  );

  uart_tx_shifter u_shift (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .pend     (hold_full_q),
    .brk      (cfg_brk),
    .nine     (cfg_nine),
    .inv      (cfg_tx_inv),
    .slots    (slots),
    .load     (load),
    .idle_nxt (idle_nxt),
    .txd      (txd)
  );

  assert_dre_fall_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(dre) |-> $past(wr_valid));
  assert_tcf_empty_R10: assert property (@(posedge clk) disable iff (rst)
    tcf |-> dre);
endmodule

// File: tb/uart_tx_framer_tb.sv
`timescale 1ns/1ps
module uart_tx_framer_tb;
  logic clk = 0, rst = 1, tick = 0, tick_seen = 0;
  logic wr_valid = 0, wr_bit9 = 0;
  logic [7:0] wr_data = 0;
  logic nine = 0, pe = 0, odd = 0, msb = 0, inv = 0, brk = 0;
  logic txd, dre, tcf;
  int n_chk = 0, n_fail = 0, slot_n = 0;
  logic log_txd [256];
  logic log_tcf [256];

  always #2.5 clk = ~clk;

  uart_tx_framer u_dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_bit9(wr_bit9), .cfg_nine(nine), .cfg_par_en(pe), .cfg_par_odd(odd),
    .cfg_msb_first(msb), .cfg_tx_inv(inv), .cfg_brk(brk),
    .txd(txd), .dre(dre), .tcf(tcf)
  );

  always @(negedge clk) tick <= rst ? 1'b0 : ~tick;
  always @(posedge clk) tick_seen <= tick;
  always @(negedge clk) if (tick_seen) begin
    log_txd[slot_n % 256] = txd;
    log_tcf[slot_n % 256] = tcf;
    slot_n = slot_n + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_frame(input logic [7:0] d, input logic b9);
    logic [8:0] ch;
    logic [11:0] f;
    int n;
    n = nine ? 9 : 8;
    ch = '0;
    if (nine) begin
      ch[7:0] = d;
      ch[8] = pe ? (($countones(d) % 2 == 1) ^ odd) : b9;
    end else begin
      ch[6:0] = d[6:0];
      ch[7] = pe ? (($countones(d[6:0]) % 2 == 1) ^ odd) : d[7];
    end
    f = '1;
    f[0] = 1'b0;
    for (int i = 1; i <= n; i++) f[i] = msb ? ch[n-i] : ch[i-1];
    return f ^ {12{inv}};
  endfunction

  task automatic write_char(input logic [7:0] d, input logic b9, output int w);
    @(negedge clk); #1;
    wr_valid = 1; wr_data = d; wr_bit9 = b9;
    @(negedge clk); #1;
    wr_valid = 0;
    w = slot_n;
  endtask

  task automatic wait_slot(input int t);
    while (slot_n < t) begin @(negedge clk); #1; end
  endtask

  task automatic send_frame(input logic [7:0] d, input logic b9, input string tag);
    int w, n;
    logic [11:0] e, a;
    n = nine ? 9 : 8;
    e = exp_frame(d, b9);
    write_char(d, b9, w);
    wait_slot(w + n + 3);
    a = '0;
    for (int i = 0; i < 12; i++) begin
      if (i <= n + 2) a[i] = log_txd[(w + i) % 256];
      else e[i] = 1'b0;
    end
    chk(a == e && log_tcf[(w + n + 2) % 256] && !log_tcf[w % 256], tag, {20'd0, a}, {20'd0, e});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int w, wb, wc, s0, bad;
    logic [11:0] ea, eb;
    repeat (5) @(negedge clk);
    #1 rst = 0;
    @(negedge clk); #1;
    // R1: reset state
    chk(txd == 1 && dre == 1 && tcf == 1, "R1 reset", {txd, dre, tcf}, 3'b111);

    // R12: first frame starts at first tick after write, R9/R10 flags after write
    @(negedge clk); #1;
    wr_valid = 1; wr_data = 8'hA5; wr_bit9 = 0;
    @(negedge clk); #1;
    wr_valid = 0;
    w = slot_n;
    chk(dre == 0 && tcf == 0, "R9 R10 flags after write", {dre, tcf}, 2'b00);
    wait_slot(w + 11);
    ea = exp_frame(8'hA5, 1'b0);
    bad = 0;
    for (int i = 0; i < 11; i++) if (log_txd[(w + i) % 256] != ea[i]) bad++;
    chk(bad == 0, "R12 start on first tick", bad, 0);

    // sweep over every format combination
    for (int c = 0; c < 16; c++) begin
      nine = c[0]; pe = c[1]; odd = c[2]; msb = c[3];
      for (int k = 0; k < 128; k++) begin
        logic [7:0] d;
        d = 8'(k * 37 + c * 11);
        if (msb)      send_frame(d, k[0], "R6 msb-first");
        else if (pe)  send_frame(d, k[0], nine ? "R4 parity 9-slot" : "R5 parity 8-slot");
        else          send_frame(d, k[0], nine ? "R2 ninth bit" : "R3 plain 8-slot");
      end
    end

    // R7: inversion
    nine = 1; pe = 1; odd = 0; msb = 0; inv = 1;
    repeat (3) @(negedge clk); #1;
    chk(txd == 0, "R7 idle inverted", txd, 0);
    send_frame(8'h3C, 1'b0, "R7 inverted frame");
    send_frame(8'hF1, 1'b1, "R7 inverted frame");
    inv = 0;
    repeat (3) @(negedge clk); #1;
    chk(txd == 1, "R7 idle restored", txd, 1);

    // R11 chaining, R9 dropped write
    nine = 0; pe = 0; odd = 0; msb = 0;
    write_char(8'h5A, 1'b0, w);
    wait_slot(w + 1);
    chk(dre == 1, "R9 dre after load", dre, 1);
    write_char(8'hC3, 1'b0, wb);
    chk(dre == 0 && tcf == 0, "R10 pending flags", {dre, tcf}, 2'b00);
    write_char(8'hFF, 1'b0, wc);
    wait_slot(w + 23);
    ea = exp_frame(8'h5A, 1'b0);
    eb = exp_frame(8'hC3, 1'b0);
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      if (log_txd[(w + i) % 256] != ea[i]) bad++;
      if (log_txd[(w + 10 + i) % 256] != eb[i]) bad++;
    end
    chk(bad == 0, "R11 back-to-back frames", bad, 0);
    bad = 0;
    for (int i = 20; i < 23; i++) if (log_txd[(w + i) % 256] != 1'b1) bad++;
    chk(bad == 0 && log_tcf[(w + 20) % 256], "R9 ignored write not sent", bad, 0);

    // R8 break, released mid-frame
    brk = 1;
    s0 = slot_n;
    wait_slot(s0 + 33);
    brk = 0;
    wait_slot(s0 + 43);
    bad = 0;
    for (int i = 0; i < 40; i++) if (log_txd[(s0 + i) % 256] != 1'b0) bad++;
    chk(bad == 0, "R8 break frames all zero", bad, 0);
    chk(log_tcf[(s0 + 5) % 256] == 0, "R10 tcf low in break", log_tcf[(s0 + 5) % 256], 0);
    bad = 0;
    for (int i = 40; i < 43; i++) if (log_txd[(s0 + i) % 256] != 1'b1) bad++;
    chk(bad == 0 && log_tcf[(s0 + 40) % 256], "R8 idle after release", bad, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule